// File: doc/BRIEF.md
# Tournament Branch Predictor

This block predicts the direction of conditional branches by running two direction predictors side by side and choosing between them per branch address. One predictor is a per-address table of 2-bit saturating counters. The other is a table of 2-bit counters indexed by a global history register, which holds the recent outcomes of all branches, XORed with address bits. A third table of 2-bit counters, also indexed per address, records which of the two has been winning recently and selects the final answer.

A lookup presents a PC and gets three results in the same cycle: the final prediction and the two component predictions. When the branch resolves, the pipeline sends an update with the PC, the actual outcome and the two component predictions it recorded at lookup time. The update trains both component counters, settles the contest in the selector, and shifts the outcome into the global history. Lookups read the state as it stood before the update edge.

Top module: `tourney_pred`

## Requirements
- R1: After reset every counter in all three tables holds 01 and the global history is all zeros, so every lookup returns 0 (not taken) on all three prediction outputs.
- R2: The per-address component is indexed by PC[9:2]. It predicts taken when its counter is 10 or 11. An update increments that counter when the outcome is taken and decrements it when the outcome is not taken.
- R3: The history component is indexed by the 8-bit global history XORed with PC[9:2]. It uses the same counter rules as R2. An update uses the history value as it stood before that update.
- R4: Each update shifts the outcome into bit 0 of the global history (taken = 1). The older bits move up one position, and bit 7 is dropped.
- R5: The final prediction equals the history component's prediction when the selector counter at PC[9:2] is 10 or 11, and the per-address component's prediction when it is 00 or 01.
- R6: When the two component predictions carried on the update port are equal, the selector counter does not change, whether both were right or both were wrong.
- R7: When the component predictions differ, the selector counter increments if the history component matched the outcome, and decrements otherwise.
- R8: When up_valid is low, no table and no history bit changes.
- R9: Every counter saturates: it stays at 11 when incremented and at 00 when decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Lookup PC |
| lk_pred | output | 1 | Final predicted direction (1 = taken) |
| lk_bim_pred | output | 1 | Per-address component prediction |
| lk_glb_pred | output | 1 | History component prediction |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome (1 = taken) |
| up_bim_pred | input | 1 | Per-address prediction recorded at lookup |
| up_glb_pred | input | 1 | History prediction recorded at lookup |

## Verification
The hardest state to reach is a selector counter in the upper half while the two components disagree for the same lookup. Reaching it needs repeated contests that the history component wins, and the history index keeps moving as outcomes shift in. The bench gets there in two ways. It often drives component predictions on the update port that differ from what the lookup returned, which forces contests in either direction. It also uses a small set of PCs so that counters saturate and the selector's choice becomes visible at the final output.

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_pred,
  output logic            lk_bim_pred,
  output logic            lk_glb_pred,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_bim_pred,
  input  logic            up_glb_pred
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0]       bim_q  [ENTRIES];
  logic [1:0]       glb_q  [ENTRIES];
  logic [1:0]       vote_q [ENTRIES];
  logic [IDX_W-1:0] ghr_q;

  wire [IDX_W-1:0] lk_idx  = lk_pc[IDX_W+1:2];
  wire [IDX_W-1:0] lk_gidx = lk_idx ^ ghr_q;
  wire [IDX_W-1:0] up_idx  = up_pc[IDX_W+1:2];
  wire [IDX_W-1:0] up_gidx = up_idx ^ ghr_q;

  assign lk_bim_pred = bim_q[lk_idx][1];
  assign lk_glb_pred = glb_q[lk_gidx][1];
  assign lk_pred     = vote_q[lk_idx][1] ? lk_glb_pred : lk_bim_pred;

  function automatic logic [1:0] step(input logic [1:0] c, input logic inc);
    if (inc) step = (c == 2'b11) ? c : c + 2'd1;
    else     step = (c == 2'b00) ? c : c - 2'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        bim_q[i]  <= 2'b01;
        glb_q[i]  <= 2'b01;
        vote_q[i] <= 2'b01;
      end
      ghr_q <= '0;
    end else if (up_valid) begin
      bim_q[up_idx]  <= step(bim_q[up_idx], up_taken);
      glb_q[up_gidx] <= step(glb_q[up_gidx], up_taken);
      if (up_bim_pred != up_glb_pred)
        vote_q[up_idx] <= step(vote_q[up_idx], up_glb_pred == up_taken);
      ghr_q <= {ghr_q[IDX_W-2:0], up_taken};
    end
  end
endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            up_valid,
  input logic [PC_W-1:0] up_pc,
  input logic            up_taken,
  input logic            up_bim_pred,
  input logic            up_glb_pred,
  input logic [IDX_W-1:0] ghr_q,
  input logic [1:0]      vote_q [1 << IDX_W]
);
  logic [IDX_W-1:0] ui;
  assign ui = up_pc[IDX_W+1:2];

  p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghr_q));

  p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (ghr_q[0] == $past(up_taken)) && (ghr_q[IDX_W-1:1] == $past(ghr_q[IDX_W-2:0])));

  p_vote_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (up_bim_pred == up_glb_pred)) |=> vote_q[$past(ui)] == $past(vote_q[ui]));

  p_vote_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && vote_q[ui] == 2'b11) |=> vote_q[$past(ui)] != 2'b00);

  p_vote_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (up_bim_pred != up_glb_pred) && (up_glb_pred == up_taken)) |=>
      vote_q[$past(ui)] >= $past(vote_q[ui]));
endmodule

bind tourney_pred tourney_pred_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_pc(up_pc),
  .up_taken(up_taken), .up_bim_pred(up_bim_pred), .up_glb_pred(up_glb_pred),
  .ghr_q(ghr_q), .vote_q(vote_q)
);

// File: tb/tourney_pred_bench.sv
module tourney_pred_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = 0;
  logic        lk_pred, lk_bim_pred, lk_glb_pred;
  logic        up_valid = 0;
  logic [31:0] up_pc = 0;
  logic        up_taken = 0, up_bim_pred = 0, up_glb_pred = 0;

  int n_tests = 0, n_fail = 0;
  int m_bim[256], m_glb[256], m_vote[256];
  int m_ghr;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourney_pred u_tourney_pred (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(lk_pred),
    .lk_bim_pred(lk_bim_pred), .lk_glb_pred(lk_glb_pred),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_bim_pred(up_bim_pred), .up_glb_pred(up_glb_pred)
  );

  function automatic int sat(int c, bit inc);
    if (inc) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic bit exp_bim(logic [31:0] pc);
    return m_bim[pc[9:2]] >= 2;
  endfunction
  function automatic bit exp_glb(logic [31:0] pc);
    return m_glb[int'(pc[9:2]) ^ m_ghr] >= 2;
  endfunction
  function automatic bit exp_final(logic [31:0] pc);
    return (m_vote[pc[9:2]] >= 2) ? exp_glb(pc) : exp_bim(pc);
  endfunction

  task automatic chk(bit act, bit exp, string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (pc=%h ghr=%h)", req, act, exp, lk_pc, m_ghr);
    end
  endtask

  task automatic look(logic [31:0] pc);
    @(negedge clk);
    lk_pc = pc;
    #1;
    chk(lk_bim_pred, exp_bim(pc), "R2 per-address prediction");
    chk(lk_glb_pred, exp_glb(pc), "R3 history prediction");
    chk(lk_pred, exp_final(pc), "R5/R6/R7 final selection");
  endtask

  task automatic upd(bit valid, logic [31:0] pc, bit tk, bit bp, bit gp);
    int i, g;
    @(negedge clk);
    up_valid = valid; up_pc = pc; up_taken = tk; up_bim_pred = bp; up_glb_pred = gp;
    @(posedge clk);
    #1;
    if (valid) begin
      i = int'(pc[9:2]);
      g = i ^ m_ghr;
      m_bim[i] = sat(m_bim[i], tk);
      m_glb[g] = sat(m_glb[g], tk);
      if (bp != gp) m_vote[i] = sat(m_vote[i], gp == tk);
      m_ghr = ((m_ghr << 1) | int'(tk)) & 8'hff;
    end
    up_valid = 0;
  endtask

  function automatic logic [31:0] mkpc(int idx);
    logic [31:0] r;
    r = $urandom;
    r[9:2] = idx[7:0];
    r[1:0] = 2'b00;
    return r;
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pc;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) begin m_bim[i] = 1; m_glb[i] = 1; m_vote[i] = 1; end
    m_ghr = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: reset state on several PCs
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); lk_pc = mkpc(k * 67); #1;
      chk(lk_pred, 1'b0, "R1 reset final");
      chk(lk_bim_pred, 1'b0, "R1 reset per-address");
      chk(lk_glb_pred, 1'b0, "R1 reset history");
    end
    // R4/R3: shift a known pattern then look up through history index
    upd(1, mkpc(3), 1, 0, 0);
    upd(1, mkpc(3), 0, 0, 0);
    upd(1, mkpc(3), 1, 0, 0);
    chk(m_ghr == 5, 1'b1, "R4 model history pattern 101");
    for (int k = 0; k < 8; k++) look(mkpc(k));
    // R7/R9: push selector at idx 5 up through saturation by forced contests
    for (int k = 0; k < 5; k++) upd(1, mkpc(5), 1, 0, 1);
    for (int k = 0; k < 4; k++) upd(1, mkpc(5), 0, 1, 0);
    look(mkpc(5));
    for (int k = 0; k < 5; k++) upd(1, mkpc(5), 0, 0, 1);
    look(mkpc(5));
    // R8: updates without the strobe have no effect
    for (int k = 0; k < 6; k++) begin
      upd(0, mkpc(k), k[0], k[1], k[2]);
      look(mkpc(k));
    end
    // R6: equal component predictions, both wrong then both right
    upd(1, mkpc(9), 1, 0, 0);
    upd(1, mkpc(9), 1, 1, 1);
    look(mkpc(9));
    // random mix
    for (int it = 0; it < 3000; it++) begin
      int idx;
      bit bp, gp, tk;
      idx = $urandom_range(0, 11);
      pc = mkpc(idx);
      look(pc);
      bp = lk_bim_pred; gp = lk_glb_pred;
      if ($urandom_range(0, 1) == 1) begin bp = 1'($urandom); gp = 1'($urandom); end
      tk = ($urandom_range(0, 9) < (idx % 4) * 3) ? 1'b1 : 1'b0;
      upd($urandom_range(0, 7) != 0, pc, tk, bp, gp);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule